// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy remainder over a stream that arrives one bit per clock, most significant bit first. The divisor is fixed at build time: a parameter gives the remainder width `CRC_W` and a parameter gives the divisor's low `CRC_W` bits. The leading divisor bit is always 1 and is not stored. The shift register computes the remainder of the message extended by `CRC_W` zero bits, but it needs no extra flush cycles to do so.

In generate mode, the block takes message bits under a valid strobe. A start strobe marks the first bit and a last strobe marks the final bit. On the cycles that follow, it shifts the remainder out on a serial output that has its own valid. The transmitted unit is therefore the message followed by the remainder, and the remainder takes the place of the appended zeros. In check mode, the block divides the whole received codeword, which is the message followed by its remainder. On the cycle after the last bit it raises a done pulse, and it raises a pass flag only if the remainder is zero.

The controller has three states. ST_IDLE waits for a start. ST_RUN accepts message bits. ST_EMIT shifts out the remainder. The transitions are as follows:
- idle-to-run: a start bit that is not also a last bit.
- run-to-run: a non-final bit, or a restart.
- run/idle-to-emit: a final bit in generate mode.
- run/idle-to-idle: a final bit in check mode.
- emit-to-idle: the last remainder bit.

Top module: `crc_ser_engine`

## Requirements
- R1: After reset, `crc_valid`, `crc_bit`, `chk_done` and `chk_ok` are all 0.
- R2: In generate mode (`mode_chk`=0 at the start bit), the emitted bits equal the remainder of (message·x^CRC_W) modulo-2 divided by (x^CRC_W + DIVISOR). The message is taken first bit first, and the remainder is emitted MSB first, starting the cycle after the last bit is accepted.
- R3: `crc_valid` stays high for exactly CRC_W consecutive cycles after a generate message and is then low. `crc_bit` is 0 whenever `crc_valid` is low.
- R4: While the remainder is being emitted, `in_valid`, `in_start`, `in_last`, `in_bit` and `mode_chk` are ignored. The emitted bits are unchanged, and no message begins.
- R5: In check mode (`mode_chk`=1 at the start bit), `chk_done` is high for exactly the one cycle after the last bit is accepted.
- R6: `chk_ok` is high only together with `chk_done`, and only when the received string divided by the divisor leaves a zero remainder. An intact message+remainder codeword passes, and a codeword with one flipped bit fails. The divisor's constant term is 1.
- R7: A bit with `in_valid` and `in_start` high clears the register before that bit is divided in, so a restart in the middle of a message discards the earlier bits.
- R8: Cycles with `in_valid` low do not change the result, and valid bits that arrive in ST_IDLE without `in_start` are ignored.
- R9: The mode is taken from `mode_chk` on the start bit only, and changes on later bits of the same message have no effect.
- R10: A single-bit message, with start and last on the same bit, is handled in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_chk | input | 1 | 0 = generate, 1 = check; sampled with the start bit |
| in_valid | input | 1 | in_bit carries a stream bit this cycle |
| in_start | input | 1 | First bit of a message |
| in_last | input | 1 | Final bit of a message |
| in_bit | input | 1 | Serial data bit |
| crc_bit | output | 1 | Serial remainder bit, MSB first |
| crc_valid | output | 1 | crc_bit is valid |
| chk_done | output | 1 | Check result is valid this cycle |
| chk_ok | output | 1 | Check passed (zero remainder) |

## Verification
Emitting the remainder and accepting a new message strobe can occur in the same cycle. Start, last and valid requested during ST_EMIT must lose to the emission. The bench holds every input strobe high on each emission cycle, including the cycle of the emit-to-idle transition. It judges the collision by comparing the emitted remainder with an independently computed long division, and it confirms that neither a check result nor a second emission follows. A second coincidence is a check result followed at once by a new message start. The bench runs back-to-back messages to confirm that the done pulse still lasts exactly one cycle.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EMIT = 2'd2
    } crc_state_e;

endpackage

// File: rtl/crc_ser_divider.sv
module crc_ser_divider #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         data_en,
    input  logic         emit_en,
    input  logic         din,
    output logic [W-1:0] rem,
    output logic         step_zero
);

    logic [W-1:0] rem_q;
    logic [W-1:0] base;
    logic [W-1:0] stepped;
    logic         fb;

    // One long-division step with the zero augmentation folded in.
    always_comb begin
        base      = load ? '0 : rem_q;
        fb        = base[W-1] ^ din;
        stepped   = {base[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
        step_zero = (stepped == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (data_en) begin
            rem_q <= stepped;
        end else if (emit_en) begin
            rem_q <= {rem_q[W-2:0], 1'b0};
        end
    end

    assign rem = rem_q;

endmodule

// File: rtl/crc_ser_bitcnt.sv
module crc_ser_bitcnt #(
    parameter int W = 8,
    localparam int CW = (W > 2) ? $clog2(W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_load,
    input  logic cnt_dec,
    output logic cnt_zero
);

    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= LAST_IDX;
        end else if (cnt_dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/crc_ser_ctrl.sv
module crc_ser_ctrl
    import crc_ser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_chk,
    input  logic in_valid,
    input  logic in_start,
    input  logic in_last,
    input  logic cnt_zero,
    input  logic step_zero,
    output logic load,
    output logic data_en,
    output logic emit_en,
    output logic cnt_load,
    output logic crc_valid,
    output logic chk_done,
    output logic chk_ok
);

    crc_state_e state_q, state_d;
    logic       mode_q;
    logic       done_q;
    logic       ok_q;
    logic       eff_chk;
    logic       last_acc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Mode latch and check result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            if (load) begin
                mode_q <= mode_chk;
            end
            done_q <= last_acc && eff_chk;
            ok_q   <= last_acc && eff_chk && step_zero;
        end
    end

    // Next state and outputs
    always_comb begin
        data_en   = 1'b0;
        emit_en   = 1'b0;
        crc_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: data_en = in_valid && in_start;
            ST_RUN:  data_en = in_valid;
            ST_EMIT: begin
                emit_en   = 1'b1;
                crc_valid = 1'b1;
            end
            default: data_en = 1'b0;
        endcase

        load     = data_en && in_start;
        eff_chk  = load ? mode_chk : mode_q;
        last_acc = data_en && in_last;
        cnt_load = last_acc && !eff_chk;

        unique case (state_q)
            ST_IDLE, ST_RUN: begin
                if (last_acc) begin
                    state_d = eff_chk ? ST_IDLE : ST_EMIT;
                end else if (data_en) begin
                    state_d = ST_RUN;
                end
            end
            ST_EMIT: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign chk_done = done_q;
    assign chk_ok   = ok_q;

endmodule

// File: rtl/crc_ser_engine.sv
module crc_ser_engine #(
    parameter int               CRC_W   = 8,
    parameter logic [CRC_W-1:0] DIVISOR = 8'h07
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_chk,
    input  logic in_valid,
    input  logic in_start,
    input  logic in_last,
    input  logic in_bit,
    output logic crc_bit,
    output logic crc_valid,
    output logic chk_done,
    output logic chk_ok
);

    logic             load;
    logic             data_en;
    logic             emit_en;
    logic             cnt_load;
    logic             cnt_zero;
    logic             step_zero;
    logic             emit_valid;
    logic [CRC_W-1:0] rem;

    crc_ser_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_chk (mode_chk),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_last  (in_last),
        .cnt_zero (cnt_zero),
        .step_zero(step_zero),
        .load     (load),
        .data_en  (data_en),
        .emit_en  (emit_en),
        .cnt_load (cnt_load),
        .crc_valid(emit_valid),
        .chk_done (chk_done),
        .chk_ok   (chk_ok)
    );

    crc_ser_divider #(.W(CRC_W), .POLY(DIVISOR)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .data_en  (data_en),
        .emit_en  (emit_en),
        .din      (in_bit),
        .rem      (rem),
        .step_zero(step_zero)
    );

    crc_ser_bitcnt #(.W(CRC_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_load(cnt_load),
        .cnt_dec (emit_en),
        .cnt_zero(cnt_zero)
    );

    assign crc_valid = emit_valid;
    assign crc_bit   = emit_valid & rem[CRC_W-1];

endmodule

// File: rtl/crc_ser_engine_chk.sv
module crc_ser_engine_chk #(
    parameter int W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic crc_bit,
    input logic crc_valid,
    input logic chk_done,
    input logic chk_ok
);

    localparam int RW = $clog2(W + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (crc_valid) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R6
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ok |-> chk_done);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(in_valid && in_last));

    // R3
    emit_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |-> (run_q < RW'(W)));

    // R3
    emit_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_valid) |-> (run_q == RW'(W)));

    // R3
    bit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_valid |-> !crc_bit);

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_valid && chk_done));

endmodule

bind crc_ser_engine crc_ser_engine_chk #(.W(CRC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .crc_bit  (crc_bit),
    .crc_valid(crc_valid),
    .chk_done (chk_done),
    .chk_ok   (chk_ok)
);

// File: tb/crc_ser_engine_tb.sv
module crc_ser_engine_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         W          = 8;
    localparam logic [W-1:0] P        = 8'h07;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_chk = 1'b0;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic in_last = 1'b0;
    logic in_bit = 1'b0;
    logic crc_bit, crc_valid, chk_done, chk_ok;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crc_ser_engine #(.CRC_W(W), .DIVISOR(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_chk(mode_chk),
        .in_valid(in_valid), .in_start(in_start), .in_last(in_last),
        .in_bit(in_bit), .crc_bit(crc_bit), .crc_valid(crc_valid),
        .chk_done(chk_done), .chk_ok(chk_ok)
    );

    // Modulo-2 long division by the full divisor {1, P}; aug appends W zeros.
    function automatic logic [W-1:0] ref_rem(logic [63:0] m, int len, bit aug);
        logic [W:0] dv;
        logic [W:0] win;
        dv  = {1'b1, P};
        win = '0;
        for (int i = 0; i < len + (aug ? W : 0); i++) begin
            win = {win[W-1:0], (i < len) ? m[len-1-i] : 1'b0};
            if (win[W]) win = win ^ dv;
        end
        return win[W-1:0];
    endfunction

    task automatic expect_eq(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_bit = 1'b0;
    endtask

    task automatic send(logic [63:0] m, int len, logic md, int gap, bit flip);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_start = (i == 0);
            in_last  = (i == len - 1);
            in_bit   = m[len-1-i];
            mode_chk = (i == 0) ? md : (flip ? ~md : md);
            @(negedge clk);
            if (gap > 0 && i != len - 1) begin
                idle_inputs();
                repeat (gap) @(negedge clk);
            end
        end
        idle_inputs();
    endtask

    task automatic collect(string req, logic [W-1:0] exp, bit noisy);
        logic [W-1:0] got;
        logic         vseen;
        got = '0; vseen = 1'b1;
        for (int k = 0; k < W; k++) begin
            vseen = vseen & crc_valid;
            got[W-1-k] = crc_bit;
            if (noisy) begin
                in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1;
                in_bit = 1'b1; mode_chk = 1'b1;
            end
            @(negedge clk);
        end
        idle_inputs();
        mode_chk = 1'b0;
        expect_eq({req, " remainder"}, 64'(got), 64'(exp));
        expect_eq("R3 valid high W cycles", 64'(vseen), 64'd1);
        expect_eq("R3 valid low after W", 64'(crc_valid), 64'd0);
        expect_eq("R4 no message begun", 64'(chk_done), 64'd0);
        @(negedge clk);
        expect_eq("R4 no emission begun", 64'(crc_valid), 64'd0);
        expect_eq("R3 crc_bit quiet", 64'(crc_bit), 64'd0);
    endtask

    task automatic t_reset();
        expect_eq("R1 crc_valid", 64'(crc_valid), 64'd0);
        expect_eq("R1 crc_bit",   64'(crc_bit),   64'd0);
        expect_eq("R1 chk_done",  64'(chk_done),  64'd0);
        expect_eq("R1 chk_ok",    64'(chk_ok),    64'd0);
    endtask

    task automatic t_gen(string req, logic [63:0] m, int len, int gap, bit flip, bit noisy);
        send(m, len, 1'b0, gap, flip);
        collect(req, ref_rem(m, len, 1'b1), noisy);
    endtask

    task automatic t_chk(string req, logic [63:0] m, int len, int flip_pos, bit mflip);
        logic [63:0] cw;
        logic        exp_ok;
        cw = (m << W) | 64'(ref_rem(m, len, 1'b1));
        if (flip_pos >= 0) cw[flip_pos] = ~cw[flip_pos];
        exp_ok = (ref_rem(cw, len + W, 1'b0) == '0);
        send(cw, len + W, 1'b1, 0, mflip);
        expect_eq({req, " R5 done pulse"}, 64'(chk_done), 64'd1);
        expect_eq({req, " R6 ok"}, 64'(chk_ok), 64'(exp_ok));
        expect_eq({req, " R9 no emission"}, 64'(crc_valid), 64'd0);
        @(negedge clk);
        expect_eq({req, " R5 done one cycle"}, 64'(chk_done), 64'd0);
        expect_eq({req, " R6 ok low"}, 64'(chk_ok), 64'd0);
    endtask

    task automatic t_restart();
        logic [63:0] m;
        m = 64'hA5C3;
        // partial message without last, then a fresh start (R7)
        in_valid = 1'b1; in_start = 1'b1; in_bit = 1'b1; mode_chk = 1'b0;
        @(negedge clk);
        in_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            in_bit = i[0];
            @(negedge clk);
        end
        idle_inputs();
        t_gen("R7 restart", m, 16, 0, 1'b0, 1'b0);
    endtask

    task automatic t_stray();
        // valid bits without start in ST_IDLE are ignored (R8)
        in_valid = 1'b1; in_bit = 1'b1; mode_chk = 1'b0;
        repeat (3) @(negedge clk);
        in_last = 1'b1;
        @(negedge clk);
        idle_inputs();
        expect_eq("R8 stray last ignored", 64'(crc_valid), 64'd0);
        t_gen("R8 gaps", 64'h3B_91F0, 24, 2, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back();
        // two check messages with no idle cycle between (R5)
        logic [63:0] cw;
        cw = (64'h5A << W) | 64'(ref_rem(64'h5A, 8, 1'b1));
        send(cw, 8 + W, 1'b1, 0, 1'b0);
        expect_eq("R5 first done", 64'(chk_done), 64'd1);
        t_chk("R5 back-to-back", 64'h1234, 16, -1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        t_gen("R2 byte", 64'h31, 8, 0, 1'b0, 1'b0);
        t_gen("R2 long", 64'hDEAD_BEEF_0123, 48, 0, 1'b0, 1'b0);
        t_gen("R2 zeros", 64'h0, 12, 0, 1'b0, 1'b0);
        t_gen("R4 noisy emit", 64'hC0FFEE, 24, 0, 1'b0, 1'b1);
        t_gen("R9 mode toggled", 64'h9E37, 16, 0, 1'b1, 1'b0);
        t_gen("R10 single one", 64'h1, 1, 0, 1'b0, 1'b0);
        t_gen("R10 single zero", 64'h0, 1, 0, 1'b0, 1'b0);

        t_chk("R6 intact", 64'h31, 8, -1, 1'b0);
        t_chk("R6 intact long", 64'hBADC_0FFE_E0, 40, -1, 1'b0);
        t_chk("R6 flip data", 64'hBADC_0FFE_E0, 40, 20, 1'b0);
        t_chk("R6 flip crc", 64'h31, 8, 0, 1'b0);
        t_chk("R9 mode toggled chk", 64'h77, 8, -1, 1'b1);
        t_chk("R10 single chk", 64'h1, 1, -1, 1'b0);

        t_restart();
        t_stray();
        t_back_to_back();

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule